// File: doc/BRIEF.md
# Integer-to-float converter

This unit turns a 64-bit integer, read either as two's-complement or as unsigned, into a binary floating-point number. The result is either double precision or single precision. Each conversion is requested with a one-cycle start pulse. A short fixed pipeline then does the work in order: it forms the absolute value, finds the leading one, and shifts it to the top of the word. It then builds the biased exponent and rounds away the low bits under one of four rounding modes.

Single-precision results come out in the double-precision register layout, as a register file that holds both widths would keep them. The exponent is rebiased for double precision, and the fraction bits beyond the 23 that single precision keeps are zero. With each result the unit also reports three things. The first is whether rounding dropped nonzero bits. The second is whether that must raise a trap, given the per-request trap enable. The third is a small class code that a status register can record.

Top module: `i2f_convert`

## Requirements
- R1: With the default MID_REG=1, a start sampled at clock edge N gives done_o high after edge N+2, for exactly one cycle per start. A start is accepted on every cycle, and done_o is low in every cycle that no start maps to (with MID_REG=0 the delay is one edge shorter).
- R2: With op_signed_i=1, int_i is two's-complement. A negative value converts to its magnitude with result bit 63 set, and the most negative value gives magnitude 2^63.
- R3: With op_signed_i=0, all 64 bits are magnitude and result bit 63 is always 0.
- R4: Packing is bit 63 sign, bits 62:52 biased exponent, and bits 51:0 fraction. The exponent equals 1023 plus the bit index of the leading one of the magnitude, plus one when rounding carries.
- R5: With op_single_i=1, the significand is rounded to 24 bits and result bits 28:0 are zero. With op_single_i=0 it is rounded to 53 bits.
- R6: rmode_i selects the rounding. 00 is nearest with ties to even, 01 is toward zero, 10 is toward plus infinity and 11 is toward minus infinity.
- R7: When rounding up overflows the kept significand, the exponent rises by one and the fraction field becomes zero.
- R8: A zero input gives an all-zero result, inexact_o=0 and class 00.
- R9: inexact_o is 1 exactly when any bit dropped by rounding is nonzero.
- R10: inx_trap_o is 1 exactly when inexact_o is 1 and inx_en_i was 1 with the start.
- R11: cls_o is 00 for zero, 01 for a positive nonzero result and 10 for a negative one. It is never 11.
- R12: While rst_n is low, done_o, result_o, inexact_o, inx_trap_o and cls_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a conversion with the operands on this cycle |
| op_signed_i | input | 1 | 1: integer is two's-complement; 0: unsigned |
| op_single_i | input | 1 | 1: round to single precision; 0: double |
| int_i | input | 64 | Integer operand |
| rmode_i | input | 2 | Rounding mode (00 nearest-even, 01 zero, 10 +inf, 11 -inf) |
| inx_en_i | input | 1 | Trap enable for inexact results |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | 64 | Packed floating-point result |
| inexact_o | output | 1 | Rounding discarded nonzero bits |
| inx_trap_o | output | 1 | Inexact result with the trap enabled |
| cls_o | output | 2 | Result class code |

## Verification
The bench builds the block with its defaults: a 64-bit integer, 52-bit and 23-bit fractions, an 11-bit exponent and the middle pipeline register present, for a three-edge latency. At these widths every leading-one position from 0 to 63 can be reached. So can both the exact and the inexact regions of each precision, the most negative signed value, and the all-ones unsigned value whose rounding carries into the exponent. Back-to-back starts with idle gaps between them exercise the three-deep pipeline.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } i2f_rmode_e;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'b00,
      CLS_POS  = 2'b01,
      CLS_NEG  = 2'b10
   } i2f_cls_e;

   typedef struct packed {
      logic       neg;
      logic       single;
      logic [1:0] rmode;
      logic       trap_en;
   } i2f_ctl_t;

endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude #(
   parameter int INT_W = 64
) (
   input  logic [INT_W-1:0] val_i,
   input  logic             is_signed_i,
   output logic             neg_o,
   output logic [INT_W-1:0] mag_o
);
   localparam logic [INT_W-1:0] ONE = {{(INT_W-1){1'b0}}, 1'b1};

   // R2: negative two's-complement operands are negated to a magnitude
   assign neg_o = is_signed_i & val_i[INT_W-1];
   assign mag_o = neg_o ? (~val_i + ONE) : val_i;
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
   parameter int INT_W = 64,
   parameter int LZ_W  = 6
) (
   input  logic [INT_W-1:0] mag_i,
   output logic [INT_W-1:0] norm_o,
   output logic [LZ_W-1:0]  lead_o
);
   localparam logic [LZ_W-1:0] TOP = LZ_W'(INT_W - 1);

   logic [LZ_W-1:0] lead_idx;
   logic [LZ_W-1:0] lz_cnt;

   // leading-one search: the highest set bit wins
   always_comb begin
      lead_idx = '0;
      for (int i = 0; i < INT_W; i++) begin
         if (mag_i[i]) lead_idx = LZ_W'(i);
      end
   end

   assign lz_cnt = TOP - lead_idx;
   assign norm_o = mag_i << lz_cnt;
   assign lead_o = lead_idx;
endmodule

// File: rtl/i2f_round.sv
module i2f_round
   import i2f_pkg::*;
#(
   parameter int INT_W     = 64,
   parameter int FRAC_W    = 52,
   parameter int SP_FRAC_W = 23,
   parameter int EXP_W     = 11,
   parameter int LZ_W      = 6,
   localparam int RES_W    = 1 + EXP_W + FRAC_W
) (
   input  logic [INT_W-1:0] norm_i,
   input  logic [LZ_W-1:0]  lead_i,
   input  logic             neg_i,
   input  logic             single_i,
   input  logic [1:0]       rmode_i,
   output logic [RES_W-1:0] result_o,
   output logic             inexact_o,
   output logic [1:0]       cls_o
);
   localparam int KEEP_W  = FRAC_W + 1;
   localparam int DP_DROP = INT_W - KEEP_W;
   localparam int SP_GAP  = FRAC_W - SP_FRAC_W;
   localparam int SP_DROP = DP_DROP + SP_GAP;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

   localparam logic [INT_W-1:0]  DP_MASK = {{KEEP_W{1'b0}}, {DP_DROP{1'b1}}};
   localparam logic [INT_W-1:0]  SP_MASK = {{(INT_W-SP_DROP){1'b0}}, {SP_DROP{1'b1}}};
   localparam logic [KEEP_W-1:0] SP_CLR  = {{(KEEP_W-SP_GAP){1'b0}}, {SP_GAP{1'b1}}};
   localparam logic [KEEP_W-1:0] SP_INC  = SP_CLR + KEEP_W'(1);

   logic [INT_W-1:0]  drop_mask, tail;
   logic              rnd_bit, sticky, lsb, bump, carry, is_zero;
   logic [KEEP_W-1:0] keep, keep_m, inc, sum;
   logic [EXP_W-1:0]  exp_f;

   always_comb begin
      // mask generator: which low bits the chosen precision throws away
      drop_mask = single_i ? SP_MASK : DP_MASK;
      tail      = norm_i & drop_mask;
      inexact_o = |tail;
      rnd_bit   = single_i ? norm_i[SP_DROP-1] : norm_i[DP_DROP-1];
      sticky    = |(tail & (drop_mask >> 1));
      lsb       = single_i ? norm_i[SP_DROP] : norm_i[DP_DROP];

      unique case (i2f_rmode_e'(rmode_i))
         RM_NEAR_EVEN: bump = rnd_bit & (sticky | lsb);
         RM_TO_ZERO:   bump = 1'b0;
         RM_TO_POS:    bump = inexact_o & ~neg_i;
         RM_TO_NEG:    bump = inexact_o & neg_i;
         default:      bump = 1'b0;
      endcase

      keep   = norm_i[INT_W-1 -: KEEP_W];
      keep_m = single_i ? (keep & ~SP_CLR) : keep;
      inc    = single_i ? SP_INC : KEEP_W'(1);
      sum    = keep_m + (bump ? inc : '0);

      // R7: the hidden one drops out only when the increment wraps the field
      is_zero = ~norm_i[INT_W-1];
      carry   = norm_i[INT_W-1] & ~sum[FRAC_W];
      exp_f   = EXP_W'(BIAS) + EXP_W'(lead_i) + EXP_W'(carry);

      result_o = is_zero ? '0 : {neg_i, exp_f, sum[FRAC_W-1:0]};
      cls_o    = is_zero ? CLS_ZERO : (neg_i ? CLS_NEG : CLS_POS);
   end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
   import i2f_pkg::*;
#(
   parameter int INT_W     = 64,
   parameter int FRAC_W    = 52,
   parameter int SP_FRAC_W = 23,
   parameter int EXP_W     = 11,
   parameter int MID_REG   = 1,
   localparam int RES_W    = 1 + EXP_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_signed_i,
   input  logic             op_single_i,
   input  logic [INT_W-1:0] int_i,
   input  logic [1:0]       rmode_i,
   input  logic             inx_en_i,
   output logic             done_o,
   output logic [RES_W-1:0] result_o,
   output logic             inexact_o,
   output logic             inx_trap_o,
   output logic [1:0]       cls_o
);
   localparam int LZ_W = $clog2(INT_W);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   // elaboration-time parameter checks
   if (FRAC_W + 1 >= INT_W) begin : g_bad_frac
      $error("i2f_convert: FRAC_W must leave at least one bit to round away");
   end
   if (SP_FRAC_W >= FRAC_W || SP_FRAC_W < 1) begin : g_bad_sp
      $error("i2f_convert: SP_FRAC_W must lie between 1 and FRAC_W-1");
   end
   if (BIAS + INT_W >= (1 << EXP_W) - 1) begin : g_bad_exp
      $error("i2f_convert: EXP_W too narrow for INT_W");
   end
   if (MID_REG != 0 && MID_REG != 1) begin : g_bad_mid
      $error("i2f_convert: MID_REG must be 0 or 1");
   end

   // stage A: operand capture with magnitude
   logic             neg_c;
   logic [INT_W-1:0] mag_c;
   logic             a_vld;
   logic [INT_W-1:0] a_mag;
   i2f_ctl_t         a_ctl;

   i2f_magnitude #(.INT_W(INT_W)) u_mag (
      .val_i       (int_i),
      .is_signed_i (op_signed_i),
      .neg_o       (neg_c),
      .mag_o       (mag_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_vld <= 1'b0;
         a_mag <= '0;
         a_ctl <= '0;
      end else begin
         a_vld <= start_i;
         if (start_i) begin
            a_mag <= mag_c;
            a_ctl <= '{neg: neg_c, single: op_single_i, rmode: rmode_i, trap_en: inx_en_i};
         end
      end
   end

   // normalize
   logic [INT_W-1:0] norm_c;
   logic [LZ_W-1:0]  lead_c;

   i2f_normalize #(.INT_W(INT_W), .LZ_W(LZ_W)) u_norm (
      .mag_i  (a_mag),
      .norm_o (norm_c),
      .lead_o (lead_c)
   );

   // stage B: optional register between normalize and round
   logic             b_vld;
   logic [INT_W-1:0] b_norm;
   logic [LZ_W-1:0]  b_lead;
   i2f_ctl_t         b_ctl;

   if (MID_REG == 1) begin : g_mid_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_vld  <= 1'b0;
            b_norm <= '0;
            b_lead <= '0;
            b_ctl  <= '0;
         end else begin
            b_vld <= a_vld;
            if (a_vld) begin
               b_norm <= norm_c;
               b_lead <= lead_c;
               b_ctl  <= a_ctl;
            end
         end
      end
   end else begin : g_mid_wire
      assign b_vld  = a_vld;
      assign b_norm = norm_c;
      assign b_lead = lead_c;
      assign b_ctl  = a_ctl;
   end

   // round and pack
   logic [RES_W-1:0] res_c;
   logic             inx_c;
   logic [1:0]       cls_c;

   i2f_round #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .SP_FRAC_W(SP_FRAC_W),
      .EXP_W(EXP_W), .LZ_W(LZ_W)
   ) u_round (
      .norm_i    (b_norm),
      .lead_i    (b_lead),
      .neg_i     (b_ctl.neg),
      .single_i  (b_ctl.single),
      .rmode_i   (b_ctl.rmode),
      .result_o  (res_c),
      .inexact_o (inx_c),
      .cls_o     (cls_c)
   );

   // stage C: registered outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o     <= 1'b0;
         result_o   <= '0;
         inexact_o  <= 1'b0;
         inx_trap_o <= 1'b0;
         cls_o      <= CLS_ZERO;
      end else begin
         done_o <= b_vld;
         if (b_vld) begin
            result_o   <= res_c;
            inexact_o  <= inx_c;
            inx_trap_o <= inx_c & b_ctl.trap_en;
            cls_o      <= cls_c;
         end
      end
   end
endmodule

module i2f_convert_chk #(
   parameter int INT_W     = 64,
   parameter int FRAC_W    = 52,
   parameter int SP_FRAC_W = 23,
   parameter int EXP_W     = 11,
   parameter int MID_REG   = 1,
   localparam int RES_W    = 1 + EXP_W + FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             op_signed_i,
   input logic             op_single_i,
   input logic             done_o,
   input logic [RES_W-1:0] result_o,
   input logic             inexact_o,
   input logic             inx_trap_o,
   input logic [1:0]       cls_o
);
   localparam int LAT  = 2 + MID_REG;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int SP_GAP = FRAC_W - SP_FRAC_W;

   logic [EXP_W-1:0] exp_fld;
   assign exp_fld = result_o[RES_W-2 -: EXP_W];

   // R1
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i, LAT));

   // R8
   zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cls_o == 2'b00) |-> (result_o == '0 && !inexact_o));

   // R10
   trap_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && inx_trap_o) |-> inexact_o);

   // R11
   sign_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cls_o != 2'b00) |-> (result_o[RES_W-1] == cls_o[1]));

   // R11
   cls_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cls_o != 2'b11));

   // R4
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cls_o != 2'b00) |->
         (int'(exp_fld) >= BIAS && int'(exp_fld) <= BIAS + INT_W));

   // R5
   single_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(op_single_i, LAT)) |-> (result_o[SP_GAP-1:0] == '0));

   // R3
   unsigned_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(op_signed_i, LAT)) |-> !result_o[RES_W-1]);
endmodule

bind i2f_convert i2f_convert_chk #(
   .INT_W(INT_W), .FRAC_W(FRAC_W), .SP_FRAC_W(SP_FRAC_W),
   .EXP_W(EXP_W), .MID_REG(MID_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .op_signed_i (op_signed_i),
   .op_single_i (op_single_i),
   .done_o      (done_o),
   .result_o    (result_o),
   .inexact_o   (inexact_o),
   .inx_trap_o  (inx_trap_o),
   .cls_o       (cls_o)
);

// File: tb/i2f_convert_bench.sv
`timescale 1ns/1ps
module i2f_convert_bench;
   localparam int MID_REG = 1;
   localparam int LAT     = 2 + MID_REG;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        op_signed_i = 1'b0;
   logic        op_single_i = 1'b0;
   logic [63:0] int_i = '0;
   logic [1:0]  rmode_i = '0;
   logic        inx_en_i = 1'b0;
   logic        done_o;
   logic [63:0] result_o;
   logic        inexact_o;
   logic        inx_trap_o;
   logic [1:0]  cls_o;

   always #4 clk = ~clk;  // 125 MHz

   i2f_convert #(.MID_REG(MID_REG)) u_i2f_convert (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .op_signed_i(op_signed_i), .op_single_i(op_single_i),
      .int_i(int_i), .rmode_i(rmode_i), .inx_en_i(inx_en_i),
      .done_o(done_o), .result_o(result_o), .inexact_o(inexact_o),
      .inx_trap_o(inx_trap_o), .cls_o(cls_o)
   );

   typedef struct {
      logic [63:0] res;
      bit          inx;
      bit          trap;
      logic [1:0]  cls;
      int          due;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // behavioural model: returns {cls, inexact, result}
   function automatic logic [66:0] model(logic [63:0] x, bit sg, bit sp, logic [1:0] rm);
      bit          neg, inx, up;
      logic [63:0] mag, rem, half;
      logic [64:0] kept, f;
      int          msb, p, sh, e;
      neg = sg && x[63];
      mag = neg ? (~x + 64'd1) : x;
      if (mag == 64'd0) return 67'd0;
      msb = 0;
      for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
      p = sp ? 24 : 53;
      if (msb < p) begin
         kept = {1'b0, mag} << (p - 1 - msb);
         rem  = 64'd0;
         half = 64'd0;
      end else begin
         sh   = msb - (p - 1);
         kept = {1'b0, mag >> sh};
         rem  = mag & ((64'd1 << sh) - 64'd1);
         half = 64'd1 << (sh - 1);
      end
      inx = (rem != 64'd0);
      case (rm)
         2'b00:   up = inx && ((rem > half) || (rem == half && kept[0]));
         2'b01:   up = 1'b0;
         2'b10:   up = inx && !neg;
         default: up = inx && neg;
      endcase
      e = msb;
      if (up) kept = kept + 65'd1;
      if (kept == (65'd1 << p)) begin
         kept = 65'd1 << (p - 1);
         e = e + 1;
      end
      f = (kept - (65'd1 << (p - 1))) << (53 - p);
      return {(neg ? 2'b10 : 2'b01), inx, neg, 11'(e + 1023), f[51:0]};
   endfunction

   task automatic issue(logic [63:0] x, bit sg, bit sp, logic [1:0] rm, bit en, string tag);
      logic [66:0] m;
      exp_t        e;
      m = model(x, sg, sp, rm);
      e.res  = m[63:0];
      e.inx  = m[64];
      e.trap = m[64] && en;
      e.cls  = m[66:65];
      e.due  = cyc + LAT;
      e.tag  = tag;
      q.push_back(e);
      start_i     = 1'b1;
      int_i       = x;
      op_signed_i = sg;
      op_single_i = sp;
      rmode_i     = rm;
      inx_en_i    = en;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      start_i = 1'b0;
      int_i   = '0;
      repeat (n) @(negedge clk);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(done_o == 1'b1, "R1", "done", 64'(done_o), 64'd1);
            chk(result_o == e.res, e.tag, "result", result_o, e.res);
            chk(inexact_o == e.inx, {e.tag, "/R9"}, "inexact", 64'(inexact_o), 64'(e.inx));
            chk(inx_trap_o == e.trap, {e.tag, "/R10"}, "trap", 64'(inx_trap_o), 64'(e.trap));
            chk(cls_o == e.cls, {e.tag, "/R11"}, "class", 64'(cls_o), 64'(e.cls));
         end else begin
            chk(done_o == 1'b0, "R1", "idle done", 64'(done_o), 64'd0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL R1 watchdog expired actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] rs;
      logic [63:0] v;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(done_o == 1'b0, "R12", "done in reset", 64'(done_o), 64'd0);
      chk(result_o == 64'd0, "R12", "result in reset", result_o, 64'd0);
      chk({inexact_o, inx_trap_o, cls_o} == 4'd0, "R12", "flags in reset",
          64'({inexact_o, inx_trap_o, cls_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: zeros
      issue(64'd0, 1, 0, 2'b00, 1, "R8");
      issue(64'd0, 0, 1, 2'b10, 1, "R8");
      // R4 / R3: small exact values
      issue(64'd1, 0, 0, 2'b00, 0, "R4");
      issue(64'd1000, 0, 1, 2'b01, 0, "R3");
      idle(4);
      // R2: negatives and most negative value
      issue(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 2'b00, 0, "R2");
      issue(64'h8000_0000_0000_0000, 1, 0, 2'b00, 0, "R2");
      issue(64'h8000_0000_0000_0000, 0, 1, 2'b00, 0, "R3");
      issue(-64'sd123456789, 1, 1, 2'b01, 0, "R2");
      // R7: all-ones unsigned rounds into the exponent
      issue(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b00, 0, "R7");
      issue(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'b10, 0, "R7");
      issue(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b01, 0, "R6");
      // R6: ties and directed modes around 2^53
      issue(64'h0020_0000_0000_0001, 0, 0, 2'b00, 0, "R6");
      issue(64'h0020_0000_0000_0003, 0, 0, 2'b00, 0, "R6");
      issue(64'h0020_0000_0000_0001, 0, 0, 2'b10, 0, "R6");
      issue(64'h0020_0000_0000_0001, 0, 0, 2'b11, 0, "R6");
      issue(-64'sh0020_0000_0000_0001, 1, 0, 2'b11, 0, "R6");
      issue(-64'sh0020_0000_0000_0001, 1, 0, 2'b10, 0, "R6");
      // R5: single precision boundary at 2^24
      issue(64'h0000_0000_0100_0001, 0, 1, 2'b00, 0, "R5");
      issue(64'h0000_0000_0100_0003, 0, 1, 2'b00, 0, "R5");
      issue(64'h0000_0000_00FF_FFFF, 0, 1, 2'b00, 0, "R5");
      issue(64'h0000_0000_01FF_FFFF, 0, 1, 2'b10, 0, "R5");
      // R10: trap enable on exact and inexact results
      issue(64'h0000_0000_0100_0001, 0, 1, 2'b00, 1, "R10");
      issue(64'h0000_0000_0000_0400, 0, 1, 2'b00, 1, "R10");
      issue(64'h0000_0000_0100_0001, 0, 1, 2'b00, 0, "R10");
      idle(5);

      // R9 / R6: pseudo-random back-to-back stream
      rs = 64'h9E37_79B9_7F4A_7C15;
      for (int k = 0; k < 400; k++) begin
         rs = rs ^ (rs << 13);
         rs = rs ^ (rs >> 7);
         rs = rs ^ (rs << 17);
         v = rs[6] ? rs : (rs >> rs[5:0]);
         issue(v, rs[7], rs[8], rs[10:9], rs[11], "R9");
         if (rs[15:12] == 4'd0) idle(2);
      end
      idle(LAT + 3);
      chk(q.size() == 0, "R1", "pending results", 64'(q.size()), 64'd0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule